// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block is the status and control word of a floating-point unit. A host reads and writes it as one 32-bit register through a simple port. The register holds four things:

- the rounding mode that the arithmetic datapath uses;
- a five-bit trap-enable field;
- five sticky exception flags;
- a condition flag that is loaded from a compare unit.

The arithmetic datapath reports exception events on a five-bit input. Each event sets its sticky flag, and the flag stays set until the host writes the register again. A host write loads the writable control bits. It also reseeds the sticky flags from the trap-enable field of the word it writes. Any event that arrives in the same cycle as the write is added on top of that reload.

The rounding mode goes to the datapath as a registered two-bit code. A write that carries an unsupported rounding code leaves the mode as it was and produces a one-cycle error pulse. The compare unit supplies a relation result and a three-bit predicate. The block works out whether the predicate holds and stores the answer in the condition flag.

Top module: `fp_status_ctrl`

## Requirements
- R1: After a synchronous active-high reset, rd_data reads 0, rnd_mode is 0 (round to nearest even) and rnd_err is 0.
- R2: Only bits 2:0 (rounding field) and 9:5 (trap enables) of wr_data are stored. Bits 31:30, 28:15 and 4:3 always read 0. Written values in bits 14:10 and 29 have no effect on those bits.
- R3: The rounding codes are 0 for nearest-even, 1 for toward zero, 2 for toward plus infinity and 3 for toward minus infinity. A write of code 0 to 3 makes rnd_mode and rd_data[2:0] equal that code from the next cycle.
- R4: A write whose rounding field is 4 to 7 (bit 2 set) leaves rnd_mode and rd_data[2:0] unchanged. rnd_err is 1 in the cycle after that write and 0 in every other cycle. The rest of the written word is still stored.
- R5: rnd_mode holds its value in every cycle that has no write, and also on a write that carries the code already in force.
- R6: Exception events come in on exc_evt with bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow and bit 4 inexact. Each event sets rd_data bit 10 plus its index from the next cycle, and that bit stays set until the next write.
- R7: A write replaces the sticky flags, rd_data[14:10], with the written trap-enable field wr_data[9:5], matched bit for bit.
- R8: exc_evt bits that arrive in the same cycle as a write are ORed into the flags after the reload.
- R9: rd_data always returns the stored control bits merged with the current sticky flags and the condition flag in bit 29.
- R10: When cmp_valid is 1, bit 29 is loaded with the predicate result. cmp_rel is 0 for less, 1 for equal, 2 for greater and 3 for unordered. The predicate holds when (cmp_pred[2] and less) or (cmp_pred[1] and equal) or (cmp_pred[0] and unordered). Bit 29 holds its value otherwise, including across host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write word |
| rd_data | output | 32 | Merged register read value |
| exc_evt | input | 5 | Exception events from the datapath |
| cmp_valid | input | 1 | Compare result valid |
| cmp_rel | input | 2 | Compare relation: less, equal, greater, unordered |
| cmp_pred | input | 3 | Compare predicate select |
| rnd_mode | output | 2 | Rounding mode driven to the datapath |
| rnd_err | output | 1 | One-cycle pulse after an unsupported rounding write |

## Verification
The embedded assertions are checked on every cycle. They cover the following:

- rnd_mode stays stable without a write and across unsupported codes;
- the error pulse is always caused by an illegal write;
- sticky flags never clear without a write, and every event reaches its flag;
- after a reload, no flag appears unless it came from the trap field or a same-cycle event;
- the condition flag holds when no compare is valid;
- the reserved read bits stay zero.

Only the bench scenarios can show the rest:

- the exact rounding encoding across all eight codes from every prior mode;
- the bit-for-bit reload across all 32 trap patterns;
- the full 32-entry compare predicate table;
- the merged read word.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_EXC   = 5;
    localparam int RND_W     = 2;
    localparam int RND_FLD_W = RND_W + 1;
    localparam int RND_LSB   = 0;
    localparam int TRAP_LSB  = 5;
    localparam int FLAG_LSB  = 10;
    localparam int COND_BIT  = 29;

    typedef enum logic [RND_W-1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_TO_ZERO   = 2'd1,
        RND_UP        = 2'd2,
        RND_DOWN      = 2'd3
    } rnd_mode_e;

    typedef enum logic [1:0] {
        REL_LESS    = 2'd0,
        REL_EQUAL   = 2'd1,
        REL_GREATER = 2'd2,
        REL_UNORD   = 2'd3
    } cmp_rel_e;

    typedef struct packed {
        logic inexact;
        logic underflow;
        logic overflow;
        logic divzero;
        logic invalid;
    } exc_t;

    typedef struct packed {
        logic       inc_less;
        logic       inc_equal;
        logic       inc_unord;
    } cmp_pred_t;

    function automatic logic rnd_code_legal(input logic [RND_FLD_W-1:0] code);
        return (code[RND_FLD_W-1] == 1'b0);
    endfunction

    function automatic logic pred_holds(input cmp_rel_e rel, input cmp_pred_t pred);
        logic r;
        r = 1'b0;
        case (rel)
            REL_LESS:    r = pred.inc_less;
            REL_EQUAL:   r = pred.inc_equal;
            REL_UNORD:   r = pred.inc_unord;
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(
        input rnd_mode_e       mode,
        input logic [NUM_EXC-1:0] trap,
        input exc_t            flags,
        input logic            cond
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[RND_LSB +: RND_W]     = mode;
        w[TRAP_LSB +: NUM_EXC]  = trap;
        w[FLAG_LSB +: NUM_EXC]  = flags;
        w[COND_BIT]             = cond;
        return w;
    endfunction

endpackage

// File: rtl/fpsc_round_trap.sv
module fpsc_round_trap
    import fpsc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [RND_FLD_W-1:0] wr_rnd,
    input  logic [NUM_EXC-1:0]   wr_trap,
    output rnd_mode_e            mode_q,
    output logic [NUM_EXC-1:0]   trap_q,
    output logic                 err_q
);

    logic      legal;
    logic      mode_chg;
    rnd_mode_e mode_new;

    always_comb begin
        legal    = rnd_code_legal(wr_rnd);
        mode_new = rnd_mode_e'(wr_rnd[RND_W-1:0]);
        mode_chg = wr_en && legal && (mode_new != mode_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RND_NEAR_EVEN;
            trap_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (mode_chg) begin
                mode_q <= mode_new;
            end
            if (wr_en) begin
                trap_q <= wr_trap;
            end
            err_q <= wr_en && !legal;
        end
    end

    p_mode_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mode_q));

    p_mode_hold_bad_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_rnd[RND_FLD_W-1]) |=> $stable(mode_q));

    p_err_cause_r4: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $past(wr_en && wr_rnd[RND_FLD_W-1]));

endmodule

// File: rtl/fpsc_sticky.sv
module fpsc_sticky
    import fpsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic reload,
    input  exc_t reload_val,
    input  exc_t evt,
    output exc_t flags_q
);

    exc_t base;

    always_comb begin
        base = reload ? reload_val : flags_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= base | evt;
        end
    end

    p_sticky_keep_r6: assert property (@(posedge clk) disable iff (rst)
        !reload |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    p_event_lands_r6: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((flags_q & $past(evt)) == $past(evt)));

    p_reload_bound_r7: assert property (@(posedge clk) disable iff (rst)
        reload |=> ((flags_q & ~($past(reload_val) | $past(evt))) == '0));

endmodule

// File: rtl/fpsc_cond.sv
module fpsc_cond
    import fpsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmp_valid,
    input  cmp_rel_e  rel,
    input  cmp_pred_t pred,
    output logic      cond_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= 1'b0;
        end else if (cmp_valid) begin
            cond_q <= pred_holds(rel, pred);
        end
    end

    p_cond_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !cmp_valid |=> $stable(cond_q));

    p_cond_never_r10: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && pred == '0) |=> !cond_q);

    p_cond_greater_r10: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && rel == REL_GREATER) |=> !cond_q);

endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
    import fpsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic [NUM_EXC-1:0] exc_evt,
    input  logic              cmp_valid,
    input  logic [1:0]        cmp_rel,
    input  logic [2:0]        cmp_pred,
    output logic [RND_W-1:0]  rnd_mode,
    output logic              rnd_err
);

    rnd_mode_e            mode_q;
    logic [NUM_EXC-1:0]   trap_q;
    exc_t                 flags_q;
    logic                 cond_q;
    logic [RND_FLD_W-1:0] wr_rnd;
    logic [NUM_EXC-1:0]   wr_trap;

    always_comb begin
        wr_rnd  = wr_data[RND_LSB +: RND_FLD_W];
        wr_trap = wr_data[TRAP_LSB +: NUM_EXC];
    end

    fpsc_round_trap u_round_trap (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_rnd  (wr_rnd),
        .wr_trap (wr_trap),
        .mode_q  (mode_q),
        .trap_q  (trap_q),
        .err_q   (rnd_err)
    );

    fpsc_sticky u_sticky (
        .clk        (clk),
        .rst        (rst),
        .reload     (wr_en),
        .reload_val (exc_t'(wr_trap)),
        .evt        (exc_t'(exc_evt)),
        .flags_q    (flags_q)
    );

    fpsc_cond u_cond (
        .clk       (clk),
        .rst       (rst),
        .cmp_valid (cmp_valid),
        .rel       (cmp_rel_e'(cmp_rel)),
        .pred      (cmp_pred_t'(cmp_pred)),
        .cond_q    (cond_q)
    );

    always_comb begin
        rnd_mode = mode_q;
        rd_data  = pack_word(mode_q, trap_q, flags_q, cond_q);
    end

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_data[31:30] == 2'b00) && (rd_data[28:15] == '0) && (rd_data[4:2] == 3'b000));

    p_cond_ignores_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cmp_valid) |=> $stable(rd_data[COND_BIT]));

endmodule

// File: tb/tb_fp_status_ctrl.sv
module tb_fp_status_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [4:0]  exc_evt;
    logic        cmp_valid;
    logic [1:0]  cmp_rel;
    logic [2:0]  cmp_pred;
    logic [1:0]  rnd_mode;
    logic        rnd_err;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;

    logic [1:0] m_rnd;
    logic [4:0] m_trap;
    logic [4:0] m_flags;
    logic       m_cond;
    logic       m_err;

    always #5 clk = ~clk;

    fp_status_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .exc_evt   (exc_evt),
        .cmp_valid (cmp_valid),
        .cmp_rel   (cmp_rel),
        .cmp_pred  (cmp_pred),
        .rnd_mode  (rnd_mode),
        .rnd_err   (rnd_err)
    );

    function automatic logic [31:0] exp_word();
        return ({31'b0, m_cond} << 29) | ({27'b0, m_flags} << 10) |
               ({27'b0, m_trap} << 5) | {30'b0, m_rnd};
    endfunction

    function automatic logic exp_pred(input logic [1:0] rel, input logic [2:0] pred);
        return (pred[2] && rel == 2'd0) || (pred[1] && rel == 2'd1) ||
               (pred[0] && rel == 2'd3);
    endfunction

    task automatic check(input string req);
        n_tests++;
        if (rd_data !== exp_word() || rnd_mode !== m_rnd || rnd_err !== m_err) begin
            n_fail++;
            $display("FAIL %s: rd=%h mode=%0d err=%0b expected rd=%h mode=%0d err=%0b",
                     req, rd_data, rnd_mode, rnd_err, exp_word(), m_rnd, m_err);
        end
    endtask

    task automatic step(input logic we, input logic [31:0] wd, input logic [4:0] evt,
                        input logic cv, input logic [1:0] rel, input logic [2:0] pred,
                        input string req);
        wr_en = we; wr_data = wd; exc_evt = evt;
        cmp_valid = cv; cmp_rel = rel; cmp_pred = pred;
        @(posedge clk);
        m_err = we && wd[2];
        if (we) begin
            if (!wd[2]) m_rnd = wd[1:0];
            m_trap  = wd[9:5];
            m_flags = wd[9:5] | evt;
        end else begin
            m_flags = m_flags | evt;
        end
        if (cv) m_cond = exp_pred(rel, pred);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; exc_evt = '0; cmp_valid = 1'b0;
        check(req);
    endtask

    task automatic wr(input logic [31:0] wd, input string req);
        step(1'b1, wd, 5'd0, 1'b0, 2'd0, 3'd0, req);
    endtask

    task automatic idle(input string req);
        step(1'b0, 32'd0, 5'd0, 1'b0, 2'd0, 3'd0, req);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        rst = 1'b1; wr_en = 0; wr_data = '0; exc_evt = '0;
        cmp_valid = 0; cmp_rel = '0; cmp_pred = '0;
        m_rnd = 0; m_trap = 0; m_flags = 0; m_cond = 0; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1");

        // R3 / R4: every code from every legal prior mode
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 8; c++) begin
                wr(32'(p), "R3");
                wr(32'(c) | (32'(c) << 5), (c < 4) ? "R3" : "R4");
                idle("R4");
            end
        end

        // R5: hold across idle cycles and same-code writes
        wr(32'd2, "R5");
        for (int i = 0; i < 4; i++) idle("R5");
        wr(32'd2, "R5");
        wr(32'd6, "R5");

        // R2: masking with dense and pseudo-random patterns
        wr(32'hFFFF_FFFF, "R2");
        wr(32'hA5A5_A5A5, "R2");
        lfsr = 32'h1357_9BDF;
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            wr(lfsr, "R2");
        end

        // R6: each event pattern sets and holds
        for (int e = 0; e < 32; e++) begin
            wr(32'd0, "R7");
            step(1'b0, 32'd0, 5'(e), 1'b0, 2'd0, 3'd0, "R6");
            idle("R6");
            step(1'b0, 32'd0, 5'(~e), 1'b0, 2'd0, 3'd0, "R6");
        end

        // R7: reload from trap field over all patterns, flags pre-saturated
        for (int t = 0; t < 32; t++) begin
            step(1'b0, 32'd0, 5'h1F, 1'b0, 2'd0, 3'd0, "R6");
            wr(32'(t) << 5 | 32'd1, "R7");
        end

        // R8: same-cycle events ORed after reload
        for (int t = 0; t < 32; t++) begin
            step(1'b1, 32'(t) << 5, 5'(t * 7 + 3), 1'b0, 2'd0, 3'd0, "R8");
        end

        // R10: full predicate table, holds across writes and idles
        for (int r = 0; r < 4; r++) begin
            for (int pd = 0; pd < 8; pd++) begin
                step(1'b0, 32'd0, 5'd0, 1'b1, 2'(r), 3'(pd), "R10");
                wr(32'h2000_0000, "R10");
                idle("R10");
            end
        end

        // R9: all fields nonzero at once
        step(1'b0, 32'd0, 5'd0, 1'b1, 2'd3, 3'd1, "R10");
        step(1'b1, 32'h0000_0143, 5'b10100, 1'b0, 2'd0, 3'd0, "R9");
        step(1'b0, 32'd0, 5'b00001, 1'b0, 2'd0, 3'd0, "R9");

        // R1: reset mid-run clears everything
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_rnd = 0; m_trap = 0; m_flags = 0; m_cond = 0; m_err = 0;
        check("R1");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule